// File: doc/BRIEF.md
# EEPROM Page-Write Sequencer

This block sits on the host side of a byte-wide parallel EEPROM bus and carries out one protected page write per request. After a start pulse it writes a fixed three-step unlock and command prefix. It then takes a page of bytes from a valid/ready source stream and writes them to consecutive addresses starting at an aligned base. Next it waits a settle period derived from the clock frequency. Finally it reads the last-written location until the device reports that its internal write has finished. Completion is judged either by a status bit that stops alternating or by a status bit that takes the true value of the data. An iteration limit ends the polling with a timeout.

A second request, protect, issues the same prefix with no page data and then waits a longer guard period before it reports done. Completion, timeout and alignment errors are one-cycle pulses, and `busy_o` spans the whole operation.

The source stream follows the usual handshake. A byte moves when `src_valid_i` and `src_ready_o` are both high at a rising clock edge. `src_ready_o` is high only while the sequencer is waiting for the next page byte. While valid is low the bus stays idle, and there is no limit on how long it may stay low. A held byte must stay stable until it is accepted.

Top module: `eeprom_page_writer`

## Requirements
- R1: During and right after reset, `ee_ce_n_o`, `ee_we_n_o` and `ee_oe_n_o` are high, while `ee_dq_oe_o`, `busy_o` and `src_ready_o` are low.
- R2: A start request whose base address has any of its low log2(PAGE) bits set gives a one-cycle `align_err_o` in the cycle after the request. It produces no bus cycle and leaves `busy_o` low.
- R3: Every operation begins with three bus writes in a fixed sequence: data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555.
- R4: A page write then writes PAGE bytes (default 128). Byte i of the stream goes to base+i, in stream order. `src_ready_o` is high only while a byte is awaited, and stalls on `src_valid_i` lose and repeat nothing.
- R5: Each bus cycle holds `ee_ce_n_o` low together with `ee_we_n_o` (write) or `ee_oe_n_o` (read) for `strobe_len_i` clocks, with a value of 0 counting as 1. Address and write data are stable for one clock before and one clock after the strobe. `ee_dq_oe_o` is high for writes only.
- R6: The first poll read strobe starts between CLK_HZ/1000 and CLK_HZ/1000+8 clocks after the last page write strobe ends.
- R7: With `poll_mode_i`=0, the block reads the last-written address. The first read is a reference. Each later read compares its bit 6 with the bit 6 of the read before it, and a match ends the write with `done_o`.
- R8: With `poll_mode_i`=1, the block reads the last-written address. It ends with `done_o` on the first read whose bit 7 equals bit 7 of the last page byte.
- R9: If MAX_POLLS comparing reads pass without a match, the block pulses `timeout_o` and not `done_o`. In mode 0 that is MAX_POLLS+1 reads in total, and in mode 1 it is MAX_POLLS reads.
- R10: A protect request issues only the three-write prefix, with no reads. `done_o` follows between CLK_HZ/100 and CLK_HZ/100+6 clocks after the last strobe ends.
- R11: `busy_o` is high from the cycle after an accepted request until the cycle in which `done_o` or `timeout_o` pulses for one cycle. Start and protect requests made while busy are ignored, and start takes priority over protect when both arrive together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a page write |
| protect_i | input | 1 | Request a protect-only sequence |
| poll_mode_i | input | 1 | 0 = alternating-bit polling, 1 = true-data polling |
| base_addr_i | input | AW | Page base address, must be page aligned |
| strobe_len_i | input | PW | Strobe width in clocks (0 acts as 1) |
| src_valid_i | input | 1 | Source byte valid |
| src_data_i | input | 8 | Source byte |
| src_ready_o | output | 1 | Sequencer accepts a byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | One-cycle polling timeout pulse |
| align_err_o | output | 1 | One-cycle unaligned-base rejection pulse |
| ee_addr_o | output | AW | Device address |
| ee_dq_o | output | 8 | Device write data |
| ee_dq_oe_o | output | 1 | Drive enable for write data |
| ee_dq_i | input | 8 | Device read data |
| ee_ce_n_o | output | 1 | Device chip enable, active low |
| ee_we_n_o | output | 1 | Device write enable, active low |
| ee_oe_n_o | output | 1 | Device output enable, active low |

## Verification
A device model in the bench answers reads with a status bit that keeps alternating, or keeps its complemented value, for a chosen number of reads. The bench checks the exact read count at which polling ends. That covers a device that is ready on the first comparison and one that never becomes ready. A design that wrongly counted the reference read as a comparison, or that compared the wrong bit, would end the write one read early or one read late. A design with an off-by-one iteration limit would report its timeout after the wrong number of reads.

A scoreboard checks every bus write, with its strobe width, against the expected prefix and page bytes. The stream is stalled between bytes, and a start and a protect request are injected in the middle of a page. If the design dropped or repeated a byte, or restarted on the request made while busy, the scoreboard would see a mismatched or extra write. The bench also measures the settle and guard gaps, checks that an unaligned base produces no bus cycle at all, and checks that a strobe length of zero still gives a one-clock strobe.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PREFIX, ST_LOAD, ST_WRITE, ST_SETTLE, ST_POLL, ST_GUARD
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD
  } bus_phase_t;

  localparam logic [1:0] LAST_STEP = 2'd2;

  // unlock/command prefix: the order is part of the device protocol
  function automatic logic [15:0] prefix_addr(input logic [1:0] step);
    case (step)
      2'd1:    return 16'h2AAA;
      default: return 16'h5555;
    endcase
  endfunction

  function automatic logic [7:0] prefix_data(input logic [1:0] step);
    case (step)
      2'd0:    return 8'hAA;
      2'd1:    return 8'h55;
      default: return 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/eepw_bus_cycle.sv
module eepw_bus_cycle
  import eepw_pkg::*;
#(
  parameter int AW = 18,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic [PW-1:0] pulse_i,
  input  logic [7:0]    dq_i,
  output logic          idle_o,
  output logic          fin_o,
  output logic [7:0]    rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [7:0]    bus_dq_o,
  output logic          bus_dq_oe_o,
  output logic          ce_n_o,
  output logic          we_n_o,
  output logic          oe_n_o
);

  bus_phase_t    phase;
  logic [PW-1:0] left;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [7:0]    rdata_q;
  logic          rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      left    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      rd_q    <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (go_i) begin
          addr_q <= addr_i;
          data_q <= wdata_i;
          rd_q   <= rd_i;
          phase  <= PH_SETUP;
        end
        PH_SETUP: begin
          left  <= (pulse_i == '0) ? '0 : pulse_i - 1'b1;
          phase <= PH_STROBE;
        end
        PH_STROBE: begin
          if (left == '0) begin
            phase <= PH_HOLD;
            if (rd_q) rdata_q <= dq_i;
          end else begin
            left <= left - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign idle_o      = (phase == PH_IDLE);
  assign fin_o       = (phase == PH_HOLD);
  assign rdata_o     = rdata_q;
  assign bus_addr_o  = addr_q;
  assign bus_dq_o    = data_q;
  assign bus_dq_oe_o = (phase != PH_IDLE) && !rd_q;
  assign ce_n_o      = (phase != PH_STROBE);
  assign we_n_o      = !((phase == PH_STROBE) && !rd_q);
  assign oe_n_o      = !((phase == PH_STROBE) && rd_q);

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_o && !oe_n_o));
  assert_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n_o) |-> $stable(bus_addr_o) && $stable(bus_dq_o));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n_o) |-> $stable(bus_addr_o) && $stable(bus_dq_o));
  assert_strobe_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_o && $past(!ce_n_o)) |-> $stable(bus_addr_o));
  assert_read_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_o |-> !bus_dq_oe_o);

endmodule

// File: rtl/eepw_delay.sv
module eepw_delay #(
  parameter int unsigned SHORT_CYC = 1000,
  parameter int unsigned LONG_CYC  = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic long_i,
  output logic fin_o
);

  localparam int unsigned CW = $clog2(LONG_CYC + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start_i) begin
      cnt <= long_i ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign fin_o = run && (cnt == '0);

  assert_delay_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o);

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int          AW        = 18,
  parameter int          PW        = 4,
  parameter int unsigned PAGE      = 128,
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned MAX_POLLS = 32'h07FF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          protect_i,
  input  logic          poll_mode_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [PW-1:0] strobe_len_i,
  input  logic          src_valid_i,
  input  logic [7:0]    src_data_i,
  output logic          src_ready_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic          align_err_o,
  output logic [AW-1:0] ee_addr_o,
  output logic [7:0]    ee_dq_o,
  output logic          ee_dq_oe_o,
  input  logic [7:0]    ee_dq_i,
  output logic          ee_ce_n_o,
  output logic          ee_we_n_o,
  output logic          ee_oe_n_o
);

  localparam int unsigned CW         = $clog2(PAGE);
  localparam int unsigned PCW        = $clog2(MAX_POLLS + 1);
  localparam int unsigned SETTLE_CYC = CLK_HZ / 1000;
  localparam int unsigned GUARD_CYC  = CLK_HZ / 100;

  seq_state_t     state;
  logic [1:0]     step;
  logic [CW-1:0]  byte_idx;
  logic [AW-1:0]  base_q, last_addr, write_addr;
  logic [7:0]     byte_q, last_data, prev_rd;
  logic           mode_q, prot_q, ref_pending;
  logic [PCW-1:0] poll_cnt;
  logic           tmr_start, tmr_long, tmr_fin;
  logic           done_q, to_q, err_q;

  logic           bus_go, bus_rd, bus_idle, bus_fin;
  logic [AW-1:0]  bus_addr;
  logic [7:0]     bus_wdata, bus_rdata;
  logic           misaligned, poll_hit, last_poll;

  assign misaligned = |base_addr_i[CW-1:0];
  assign write_addr = base_q + AW'(byte_idx);
  assign poll_hit   = mode_q ? ~|((bus_rdata ^ last_data) & 8'h80)
                             : ~|((bus_rdata ^ prev_rd) & 8'h40);
  assign last_poll  = (poll_cnt == PCW'(MAX_POLLS - 1));

  always_comb begin
    bus_addr  = last_addr;
    bus_wdata = byte_q;
    bus_rd    = 1'b0;
    case (state)
      ST_PREFIX: begin
        bus_addr  = AW'(prefix_addr(step));
        bus_wdata = prefix_data(step);
      end
      ST_WRITE: bus_addr = write_addr;
      ST_POLL:  bus_rd   = 1'b1;
      default: ;
    endcase
  end

  assign bus_go = bus_idle &&
                  (state == ST_PREFIX || state == ST_WRITE || state == ST_POLL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      step        <= '0;
      byte_idx    <= '0;
      base_q      <= '0;
      last_addr   <= '0;
      byte_q      <= '0;
      last_data   <= '0;
      prev_rd     <= '0;
      mode_q      <= 1'b0;
      prot_q      <= 1'b0;
      ref_pending <= 1'b0;
      poll_cnt    <= '0;
      tmr_start   <= 1'b0;
      tmr_long    <= 1'b0;
      done_q      <= 1'b0;
      to_q        <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      tmr_start <= 1'b0;
      done_q    <= 1'b0;
      to_q      <= 1'b0;
      err_q     <= 1'b0;
      case (state)
        ST_IDLE: begin
          step <= '0;
          if (start_i) begin
            if (misaligned) begin
              err_q <= 1'b1;
            end else begin
              state  <= ST_PREFIX;
              base_q <= base_addr_i;
              mode_q <= poll_mode_i;
              prot_q <= 1'b0;
            end
          end else if (protect_i) begin
            state  <= ST_PREFIX;
            prot_q <= 1'b1;
          end
        end
        ST_PREFIX: if (bus_fin) begin
          if (step == LAST_STEP) begin
            byte_idx <= '0;
            if (prot_q) begin
              state     <= ST_GUARD;
              tmr_start <= 1'b1;
              tmr_long  <= 1'b1;
            end else begin
              state <= ST_LOAD;
            end
          end else begin
            step <= step + 1'b1;
          end
        end
        ST_LOAD: if (src_valid_i) begin
          byte_q <= src_data_i;
          state  <= ST_WRITE;
        end
        ST_WRITE: if (bus_fin) begin
          last_addr <= write_addr;
          last_data <= byte_q;
          if (byte_idx == CW'(PAGE - 1)) begin
            state     <= ST_SETTLE;
            tmr_start <= 1'b1;
            tmr_long  <= 1'b0;
          end else begin
            byte_idx <= byte_idx + 1'b1;
            state    <= ST_LOAD;
          end
        end
        ST_SETTLE: if (tmr_fin) begin
          state       <= ST_POLL;
          poll_cnt    <= '0;
          ref_pending <= !mode_q;
        end
        ST_POLL: if (bus_fin) begin
          prev_rd <= bus_rdata;
          if (ref_pending) begin
            ref_pending <= 1'b0;
          end else if (poll_hit) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else if (last_poll) begin
            state <= ST_IDLE;
            to_q  <= 1'b1;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        ST_GUARD: if (tmr_fin) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  eepw_bus_cycle #(.AW(AW), .PW(PW)) u_bus (
    .clk(clk), .rst_n(rst_n), .go_i(bus_go), .rd_i(bus_rd),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .pulse_i(strobe_len_i),
    .dq_i(ee_dq_i), .idle_o(bus_idle), .fin_o(bus_fin), .rdata_o(bus_rdata),
    .bus_addr_o(ee_addr_o), .bus_dq_o(ee_dq_o), .bus_dq_oe_o(ee_dq_oe_o),
    .ce_n_o(ee_ce_n_o), .we_n_o(ee_we_n_o), .oe_n_o(ee_oe_n_o)
  );

  eepw_delay #(.SHORT_CYC(SETTLE_CYC), .LONG_CYC(GUARD_CYC)) u_delay (
    .clk(clk), .rst_n(rst_n), .start_i(tmr_start), .long_i(tmr_long),
    .fin_o(tmr_fin)
  );

  assign src_ready_o = (state == ST_LOAD);
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = to_q;
  assign align_err_o = err_q;

  assert_ready_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready_o |-> busy_o && ee_ce_n_o);
  assert_align_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |-> !busy_o && ee_ce_n_o);
  assert_end_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || timeout_o) |-> !busy_o && $past(busy_o));
  assert_one_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));
  assert_poll_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < PCW'(MAX_POLLS));
  assert_protect_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && prot_q) |-> ee_oe_n_o);

endmodule

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;

  localparam int AW = 18, PW = 4, PAGE = 128;
  localparam int CLK_HZ = 200_000, MAXP = 16;
  localparam int SHORT = CLK_HZ / 1000, LONG = CLK_HZ / 100;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, protect_i = 0, poll_mode_i = 0;
  logic [AW-1:0] base_addr_i = '0;
  logic [PW-1:0] strobe_len_i = 4'd2;
  logic src_valid_i = 0;
  logic [7:0] src_data_i = '0;
  logic src_ready_o, busy_o, done_o, timeout_o, align_err_o;
  logic [AW-1:0] ee_addr_o;
  logic [7:0] ee_dq_o, ee_dq_i;
  logic ee_dq_oe_o, ee_ce_n_o, ee_we_n_o, ee_oe_n_o;

  always #10 clk = ~clk;

  eeprom_page_writer #(.AW(AW), .PW(PW), .PAGE(PAGE), .CLK_HZ(CLK_HZ),
                       .MAX_POLLS(MAXP)) uut (.*);

  int total = 0, bad = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // device model
  int rd_count = 0, busy_reads = 0;
  bit dmode = 0;
  logic [7:0] last_true = '0;
  always_comb begin
    int k;
    ee_dq_i = 8'h1B;
    k = (rd_count < busy_reads) ? rd_count : busy_reads - 1;
    if (k < 0) k = 0;
    if (!dmode) ee_dq_i[6] = k[0];
    else        ee_dq_i[7] = (rd_count < busy_reads) ? ~last_true[7] : last_true[7];
  end

  // scoreboard
  typedef struct { logic [AW-1:0] a; logic [7:0] d; } wr_t;
  wr_t exp_q[$];
  int cyc = 0, bus_active = 0, we_w = 0, exp_w = 2;
  int last_we_rise = 0, first_oe = -1, rd_addr_bad = 0;
  logic [AW-1:0] exp_rd_addr = '0;
  logic prev_we = 1, prev_oe = 1;

  always @(negedge clk) begin
    cyc++;
    if (!ee_ce_n_o) bus_active++;
    if (!ee_we_n_o) begin
      we_w++;
      if (!ee_dq_oe_o) check(0, "R5", "dq drive during write", 0, 1);
    end
    if (!prev_we && ee_we_n_o) begin
      wr_t e;
      check(we_w == exp_w, "R5", "write strobe width", we_w, exp_w);
      if (exp_q.size() == 0) check(0, "R4", "unexpected write addr", ee_addr_o, 0);
      else begin
        e = exp_q.pop_front();
        check(ee_addr_o == e.a, "R3/R4", "write addr", ee_addr_o, e.a);
        check(ee_dq_o == e.d, "R3/R4", "write data", ee_dq_o, e.d);
      end
      last_we_rise = cyc;
      we_w = 0;
    end
    if (prev_oe && !ee_oe_n_o) begin
      if (first_oe < 0) first_oe = cyc;
      if (ee_addr_o != exp_rd_addr) rd_addr_bad++;
    end
    if (!prev_oe && ee_oe_n_o) rd_count++;
    prev_we = ee_we_n_o;
    prev_oe = ee_oe_n_o;
  end

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37 + seed) & 255);
  endfunction

  task automatic push_prefix();
    exp_q.push_back('{18'h05555, 8'hAA});
    exp_q.push_back('{18'h02AAA, 8'h55});
    exp_q.push_back('{18'h05555, 8'hA0});
  endtask

  task automatic wait_end(output bit gd, output bit gt, output int ecyc);
    gd = 0; gt = 0;
    do @(negedge clk); while (!done_o && !timeout_o);
    gd = done_o; gt = timeout_o; ecyc = cyc;
    check(!busy_o, "R11", "busy low at end pulse", busy_o, 0);
    @(negedge clk);
    check(!done_o && !timeout_o, "R11", "end pulse one cycle", done_o | timeout_o, 0);
  endtask

  task automatic page_op(input logic [AW-1:0] base, input bit mode, input int b,
                         input int plen, input bit gap, input int seed,
                         input bit exp_to, input int exp_reads, input bit intrude);
    bit gd, gt;
    int ecyc;
    strobe_len_i = PW'(plen);
    exp_w = (plen == 0) ? 1 : plen;
    dmode = mode; busy_reads = b; rd_count = 0; first_oe = -1; rd_addr_bad = 0;
    exp_rd_addr = base + AW'(PAGE - 1);
    last_true = pat(PAGE - 1, seed);
    push_prefix();
    for (int i = 0; i < PAGE; i++) exp_q.push_back('{base + AW'(i), pat(i, seed)});
    @(negedge clk);
    start_i = 1; base_addr_i = base; poll_mode_i = mode;
    @(negedge clk);
    start_i = 0;
    check(busy_o, "R11", "busy after start", busy_o, 1);
    check(!src_ready_o, "R4", "ready low during prefix", src_ready_o, 0);
    for (int i = 0; i < PAGE; i++) begin
      if (gap && (i % 3 == 1)) repeat (2) @(negedge clk);
      if (intrude && i == 20) begin
        start_i = 1; protect_i = 1; base_addr_i = 18'h01000; poll_mode_i = !mode;
        @(negedge clk);
        start_i = 0; protect_i = 0;
      end
      src_valid_i = 1; src_data_i = pat(i, seed);
      while (!src_ready_o) @(negedge clk);
      @(negedge clk);
      src_valid_i = 0;
    end
    wait_end(gd, gt, ecyc);
    if (exp_to) check(gt && !gd, mode ? "R9" : "R9", "timeout flagged", gt, 1);
    else        check(gd && !gt, mode ? "R8" : "R7", "done flagged", gd, 1);
    check(rd_count == exp_reads, mode ? "R8" : "R7", "poll read count", rd_count, exp_reads);
    check(rd_addr_bad == 0, "R7", "poll reads last address", rd_addr_bad, 0);
    check(exp_q.size() == 0, "R4", "all page writes seen", exp_q.size(), 0);
    check(first_oe - last_we_rise >= SHORT && first_oe - last_we_rise <= SHORT + 8,
          "R6", "settle gap", first_oe - last_we_rise, SHORT);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit gd, gt;
    int ecyc, act0;
    repeat (3) @(negedge clk);
    check(ee_ce_n_o && ee_we_n_o && ee_oe_n_o, "R1", "strobes high in reset", 0, 1);
    check(!busy_o && !src_ready_o && !ee_dq_oe_o, "R1", "idle outputs in reset", busy_o, 0);
    rst_n = 1;
    @(negedge clk);
    check(ee_ce_n_o && !busy_o, "R1", "idle after reset", busy_o, 0);

    // R2 unaligned base
    act0 = bus_active;
    start_i = 1; base_addr_i = 18'h00081;
    @(negedge clk);
    check(align_err_o, "R2", "align error pulse", align_err_o, 1);
    check(!busy_o, "R2", "busy stays low", busy_o, 0);
    start_i = 0;
    @(negedge clk);
    check(!align_err_o, "R2", "align error one cycle", align_err_o, 0);
    repeat (10) @(negedge clk);
    check(bus_active == act0, "R2", "no bus activity", bus_active, act0);

    page_op(18'h00400, 0, 5, 2, 0, 3, 0, 6, 0);        // R7
    page_op(18'h3FF80, 1, 3, 3, 1, 200, 0, 4, 0);      // R8, stalls
    page_op(18'h00080, 1, 0, 0, 0, 77, 0, 1, 0);       // R8 immediate, R5 len 0
    page_op(18'h00100, 0, 1000, 1, 0, 9, 1, MAXP + 1, 0); // R9 toggle
    page_op(18'h00200, 1, 1000, 1, 0, 140, 1, MAXP, 0);   // R9 data
    page_op(18'h00300, 0, 1, 2, 1, 51, 0, 2, 1);       // R11 ignored requests

    // R10 protect only
    exp_w = 2; strobe_len_i = 4'd2; rd_count = 0;
    push_prefix();
    @(negedge clk);
    protect_i = 1;
    @(negedge clk);
    protect_i = 0;
    check(busy_o, "R11", "busy after protect", busy_o, 1);
    wait_end(gd, gt, ecyc);
    check(gd && !gt, "R10", "protect done", gd, 1);
    check(rd_count == 0, "R10", "no reads in protect", rd_count, 0);
    check(exp_q.size() == 0, "R3", "prefix complete", exp_q.size(), 0);
    check(ecyc - last_we_rise >= LONG && ecyc - last_we_rise <= LONG + 6,
          "R10", "guard wait", ecyc - last_we_rise, LONG);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule